// File: doc/BRIEF.md
# Multichannel Sampling-ADC Scan Sequencer

This block sits on the host side of a 12-bit sampling converter with a start pulse, a busy/done status line and a byte-wide or word-wide parallel output. It scans a bank of analog input channels round-robin at the highest rate the converter allows. For each conversion it lowers chip select, waits a programmable setup time, and then issues a start pulse of programmable width. It then watches the status line.

The channel select is moved to the next input as soon as the status line shows that a conversion is running. At that point the track/hold is already holding, so the multiplexer can switch while the current conversion is still in progress. When the status line returns high, the result is read. The read is either one 12-bit word, or two byte reads with a byte-select output toggled between them, in left- or right-justified layout. The two bytes are rebuilt into 12 bits. The result is then sign-extended (bipolar, two's complement) or zero-extended (unipolar, straight binary) to 16 bits. It leaves on a valid/ready stream together with the number of the channel that produced it.

If the status line fails to fall or fails to rise within a bounded number of cycles, the sequencer reports an error pulse, abandons that sample and starts again. The next conversion is not started until the previous result has been taken.

Top module: `adc_scan_seq`

## Requirements
- R1: While reset is held, csN, scN and oeN are high, outValid and errTimeout are low, and chanSel is 0.
- R2: Before every falling edge of scN, csN has been low with scN high for exactly SETUP_CYC cycles. scN then stays low for exactly PULSE_CYC cycles, and scN is never low while csN is high.
- R3: One cycle after eocIn is first seen low in a conversion, chanSel moves to the next channel, wrapping from NUM_CH-1 to 0. It changes at no other time.
- R4: oeN is driven low only while eocIn is high and the conversion has finished.
- R5: With wideRead=1, the result is read once with byteSel=0, and the sample is dataIn[11:0].
- R6: With wideRead=0 and rightJust=0, two reads are made on dataIn[11:4]: first with byteSel=0, then with byteSel=1. The sample is the first byte followed by bits [7:4] of the second byte.
- R7: With wideRead=0 and rightJust=1, the sample is bits [3:0] of the first byte (byteSel=0) followed by the whole second byte (byteSel=1). The upper nibble of the first byte is ignored.
- R8: outData[11:0] is the sample. With bipolar=1, outData[15:12] repeats sample bit 11. With bipolar=0, outData[15:12] is zero.
- R9: outChan is the channel that was selected when the conversion's start pulse began, not the channel selected afterwards.
- R10: While outValid is high and outReady is low, outValid, outData and outChan hold, and no new start pulse is issued.
- R11: If eocIn does not fall, or does not rise again, within TIMEOUT_CYC cycles, errTimeout pulses for one cycle, csN rises, no sample is produced and a new conversion is started. The channel has advanced only if eocIn had already fallen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wideRead | input | 1 | 1: single 12-bit read; 0: two byte reads |
| bipolar | input | 1 | 1: two's complement samples, sign-extend |
| rightJust | input | 1 | Byte layout for two-byte reads (1: right-justified) |
| eocIn | input | 1 | Converter status, low while converting |
| dataIn | input | 12 | Converter data bus (byte reads use bits 11:4) |
| csN | output | 1 | Chip select, active low |
| scN | output | 1 | Start convert, active low |
| oeN | output | 1 | Output enable, active low |
| byteSel | output | 1 | 0: first (high) byte, 1: second (low) byte |
| chanSel | output | CH_W | Analog multiplexer channel select |
| outValid | output | 1 | Result stream valid |
| outReady | input | 1 | Result stream ready |
| outData | output | 16 | Extended sample |
| outChan | output | CH_W | Channel the sample came from |
| errTimeout | output | 1 | One-cycle pulse on a status-line timeout |

## Verification
The bench sweeps all eight combinations of read width, coding and justification. In each it runs several conversions whose values include all-zero, all-one, midscale and just-below-midscale codes as well as channel-dependent arithmetic patterns. A swapped nibble, a wrong sign source or a wrong byte order therefore shows up as a value mismatch in a specific mode. Data lines that the byte layout must ignore carry non-zero junk. Scanning more conversions than there are channels exercises the wrap, and the channel tag tells the sampled channel apart from the pre-selected one. Two fault runs hold the status line high and then low, so that each timeout path and its effect on the channel are seen separately.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int SAMPLE_W = 12;
  localparam int BYTE_W   = 8;
  localparam int OUT_W    = 16;

  typedef enum logic [3:0] {
    S_IDLE, S_SETUP, S_PULSE, S_WFALL, S_WRISE,
    S_RH0, S_RH1, S_RL0, S_RL1, S_OUT
  } seqState_t;

  typedef struct packed {
    logic advChan;   // conversion running: step channel, latch sampled one
    logic capHi;     // store first byte
    logic loadWide;  // load result from a full-width read
    logic loadPair;  // load result from stored byte plus current byte
  } seqStrobe_t;
endpackage

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int SETUP_CYC   = 2,
  parameter int PULSE_CYC   = 3,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       eocIn,
  input  logic       wideRead,
  input  logic       outReady,
  output logic       csN,
  output logic       scN,
  output logic       oeN,
  output logic       byteSel,
  output logic       outValid,
  output logic       errTimeout,
  output seqStrobe_t strobe
);
  localparam int MAX_A = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int MAX_C = (MAX_A > TIMEOUT_CYC) ? MAX_A : TIMEOUT_CYC;
  localparam int CNT_W = $clog2(MAX_C + 1);

  seqState_t state, nxt;
  logic [CNT_W-1:0] cnt;
  logic errNow;

  always_comb begin
    nxt    = state;
    strobe = '0;
    errNow = 1'b0;
    unique case (state)
      S_IDLE:  nxt = S_SETUP;
      S_SETUP: if (cnt == CNT_W'(SETUP_CYC - 1)) nxt = S_PULSE;
      S_PULSE: if (cnt == CNT_W'(PULSE_CYC - 1)) nxt = S_WFALL;
      S_WFALL: begin
        if (!eocIn) begin
          strobe.advChan = 1'b1;
          nxt = S_WRISE;
        end else if (cnt == CNT_W'(TIMEOUT_CYC - 1)) begin
          errNow = 1'b1;
          nxt = S_IDLE;
        end
      end
      S_WRISE: begin
        if (eocIn) nxt = S_RH0;
        else if (cnt == CNT_W'(TIMEOUT_CYC - 1)) begin
          errNow = 1'b1;
          nxt = S_IDLE;
        end
      end
      S_RH0:   nxt = S_RH1;
      S_RH1: begin
        strobe.capHi = 1'b1;
        if (wideRead) begin
          strobe.loadWide = 1'b1;
          nxt = S_OUT;
        end else nxt = S_RL0;
      end
      S_RL0:   nxt = S_RL1;
      S_RL1: begin
        strobe.loadPair = 1'b1;
        nxt = S_OUT;
      end
      S_OUT:   if (outReady) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      cnt        <= '0;
      errTimeout <= 1'b0;
    end else begin
      state      <= nxt;
      cnt        <= (nxt != state) ? '0 : cnt + 1'b1;
      errTimeout <= errNow;
    end
  end

  assign csN      = (state == S_IDLE) || (state == S_OUT);
  assign scN      = (state != S_PULSE);
  assign oeN      = !((state == S_RH0) || (state == S_RH1) ||
                      (state == S_RL0) || (state == S_RL1));
  assign byteSel  = (state == S_RL0) || (state == S_RL1);
  assign outValid = (state == S_OUT);
endmodule

// File: rtl/adc_scan_dp.sv
module adc_scan_dp
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          strobe,
  input  logic [SAMPLE_W-1:0] dataIn,
  input  logic                bipolar,
  input  logic                rightJust,
  output logic [CH_W-1:0]     chanSel,
  output logic [OUT_W-1:0]    outData,
  output logic [CH_W-1:0]     outChan
);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);
  localparam int EXT_W = OUT_W - SAMPLE_W;

  logic [BYTE_W-1:0]   hiByte;
  logic [BYTE_W-1:0]   busByte;
  logic [SAMPLE_W-1:0] pairVal, sample;

  assign busByte = dataIn[SAMPLE_W-1 -: BYTE_W];
  assign pairVal = rightJust ? {hiByte[SAMPLE_W-BYTE_W-1:0], busByte}
                             : {hiByte, busByte[BYTE_W-1 -: SAMPLE_W-BYTE_W]};
  assign sample  = strobe.loadWide ? dataIn : pairVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanSel <= '0;
      outChan <= '0;
      hiByte  <= '0;
      outData <= '0;
    end else begin
      if (strobe.advChan) begin
        outChan <= chanSel;
        chanSel <= (chanSel == LAST_CH) ? '0 : chanSel + 1'b1;
      end
      if (strobe.capHi) hiByte <= busByte;
      if (strobe.loadWide || strobe.loadPair)
        outData <= {{EXT_W{bipolar & sample[SAMPLE_W-1]}}, sample};
    end
  end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int SETUP_CYC   = 2,
  parameter int PULSE_CYC   = 3,
  parameter int TIMEOUT_CYC = 64,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wideRead,
  input  logic            bipolar,
  input  logic            rightJust,
  input  logic            eocIn,
  input  logic [11:0]     dataIn,
  output logic            csN,
  output logic            scN,
  output logic            oeN,
  output logic            byteSel,
  output logic [CH_W-1:0] chanSel,
  output logic            outValid,
  input  logic            outReady,
  output logic [15:0]     outData,
  output logic [CH_W-1:0] outChan,
  output logic            errTimeout
);
  seqStrobe_t strobe;

  adc_scan_ctrl #(
    .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) ctrl (
    .clk(clk), .rstN(rstN), .eocIn(eocIn), .wideRead(wideRead),
    .outReady(outReady), .csN(csN), .scN(scN), .oeN(oeN),
    .byteSel(byteSel), .outValid(outValid), .errTimeout(errTimeout),
    .strobe(strobe)
  );

  adc_scan_dp #(.NUM_CH(NUM_CH), .CH_W(CH_W)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dataIn(dataIn),
    .bipolar(bipolar), .rightJust(rightJust), .chanSel(chanSel),
    .outData(outData), .outChan(outChan)
  );
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input logic            clk,
  input logic            rstN,
  input logic            eocIn,
  input logic            csN,
  input logic            scN,
  input logic            oeN,
  input logic [CH_W-1:0] chanSel,
  input logic            outValid,
  input logic            outReady,
  input logic [15:0]     outData,
  input logic [CH_W-1:0] outChan,
  input logic            errTimeout
);
  a_r2_cs_before_sc: assert property (@(posedge clk) disable iff (!rstN)
    $fell(scN) |-> $past(!csN));

  a_r2_sc_inside_cs: assert property (@(posedge clk) disable iff (!rstN)
    !scN |-> !csN);

  a_r3_chan_step: assert property (@(posedge clk) disable iff (!rstN)
    (chanSel != $past(chanSel)) |->
      chanSel == (($past(chanSel) == CH_W'(NUM_CH - 1)) ? '0 : $past(chanSel) + 1'b1));

  a_r4_read_after_eoc: assert property (@(posedge clk) disable iff (!rstN)
    !oeN |-> eocIn);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outChan)));

  a_r10_no_start: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> scN);

  a_r11_err_release: assert property (@(posedge clk) disable iff (!rstN)
    errTimeout |-> (csN && !outValid));
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) chk (
  .clk(clk), .rstN(rstN), .eocIn(eocIn), .csN(csN), .scN(scN), .oeN(oeN),
  .chanSel(chanSel), .outValid(outValid), .outReady(outReady),
  .outData(outData), .outChan(outChan), .errTimeout(errTimeout)
);

// File: tb/adc_scan_seq_test.sv
module adc_scan_seq_test;
  localparam int NUM_CH = 4;
  localparam int SETUP_CYC = 2;
  localparam int PULSE_CYC = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wideRead = 1'b1, bipolar = 1'b0, rightJust = 1'b0;
  logic eocIn;
  logic [11:0] dataIn;
  logic csN, scN, oeN, byteSel, outValid, errTimeout;
  logic outReady = 1'b0;
  logic [1:0] chanSel, outChan;
  logic [15:0] outData;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  adc_scan_seq #(.NUM_CH(NUM_CH), .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC)) uut (
    .clk(clk), .rstN(rstN), .wideRead(wideRead), .bipolar(bipolar),
    .rightJust(rightJust), .eocIn(eocIn), .dataIn(dataIn), .csN(csN),
    .scN(scN), .oeN(oeN), .byteSel(byteSel), .chanSel(chanSel),
    .outValid(outValid), .outReady(outReady), .outData(outData),
    .outChan(outChan), .errTimeout(errTimeout)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] genVal(input int s, input logic [1:0] c);
    case (s)
      0: return 12'h000;
      1: return 12'hFFF;
      2: return 12'h800;
      3: return 12'h7FF;
      default: return 12'((s * 419 + int'(c) * 241 + 77) & 12'hFFF);
    endcase
  endfunction

  // converter model, updates away from the active edge
  logic modelEoc = 1'b1;
  logic converting = 1'b0;
  logic prevSc = 1'b1;
  int mCnt = 0;
  int seqNum = 0;
  logic [11:0] lastVal = 12'h0;
  logic [1:0] lastChan = 2'd0;
  bit noFall = 0, noRise = 0;

  always @(negedge clk) begin
    if (!rstN) begin
      modelEoc <= 1'b1;
      converting <= 1'b0;
      prevSc <= 1'b1;
    end else begin
      prevSc <= scN;
      if (prevSc && !scN && !csN) begin
        lastVal <= genVal(seqNum, chanSel);
        lastChan <= chanSel;
        seqNum <= seqNum + 1;
        modelEoc <= 1'b1;
        converting <= 1'b1;
        mCnt <= 0;
      end else if (converting) begin
        mCnt <= mCnt + 1;
        if (mCnt == 1 && !noFall) modelEoc <= 1'b0;
        if (mCnt == 7 && !noRise) begin
          modelEoc <= 1'b1;
          converting <= 1'b0;
        end
      end
    end
  end

  assign eocIn = modelEoc;

  logic [3:0] extN;
  logic [7:0] byteOut;
  always_comb begin
    extN = bipolar ? {4{lastVal[11]}} : 4'h0;
    if (byteSel) byteOut = rightJust ? lastVal[7:0] : {lastVal[3:0], 4'h0};
    else         byteOut = rightJust ? {extN, lastVal[11:8]} : lastVal[11:4];
    if (oeN) dataIn = 12'h000;
    else if (wideRead) dataIn = lastVal;
    else dataIn = {byteOut, 4'h5};
  end

  // protocol monitors
  int csLowCnt = 0, scLowCnt = 0, earlyReads = 0;
  logic prevEoc = 1'b1, chanPend = 1'b0;
  logic [1:0] chanBefore = 2'd0;
  always @(negedge clk) begin
    if (rstN) begin
      if (!scN && prevSc) begin
        chk(csLowCnt == SETUP_CYC, "R2 cs setup cycles", csLowCnt, SETUP_CYC);
        csLowCnt <= 0;
      end else if (!csN && scN) csLowCnt <= csLowCnt + 1;
      else if (csN) csLowCnt <= 0;
      if (!scN) scLowCnt <= scLowCnt + 1;
      else if (!prevSc) begin
        chk(scLowCnt == PULSE_CYC, "R2 start pulse width", scLowCnt, PULSE_CYC);
        scLowCnt <= 0;
      end
      if (!oeN && !eocIn) earlyReads <= earlyReads + 1;
      if (chanPend) begin
        chk(chanSel == 2'(chanBefore + 1), "R3 channel advance", chanSel, 2'(chanBefore + 1));
        chanPend <= 1'b0;
      end
      if (prevEoc && !eocIn) begin
        chanPend <= 1'b1;
        chanBefore <= chanSel;
      end
      prevEoc <= eocIn;
    end
  end

  task automatic waitValid(output bit ok);
    ok = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (outValid) begin
        ok = 1;
        break;
      end
    end
    chk(ok, "R10 result arrives", int'(ok), 1);
  endtask

  task automatic acceptOut;
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
  endtask

  task automatic checkSample(input bit hold);
    bit ok;
    logic [11:0] v;
    logic [15:0] snap;
    waitValid(ok);
    if (!ok) return;
    v = lastVal;
    if (wideRead)       chk(outData[11:0] == v, "R5 wide sample", outData[11:0], v);
    else if (rightJust) chk(outData[11:0] == v, "R7 right-justified sample", outData[11:0], v);
    else                chk(outData[11:0] == v, "R6 left-justified sample", outData[11:0], v);
    chk(outData[15:12] == ((bipolar && v[11]) ? 4'hF : 4'h0), "R8 extension",
        outData[15:12], (bipolar && v[11]) ? 4'hF : 4'h0);
    chk(outChan == lastChan, "R9 sampled channel tag", outChan, lastChan);
    if (hold) begin
      snap = outData;
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        chk(outValid && outData == snap && scN && csN, "R10 hold while not ready",
            outData, snap);
      end
    end
  endtask

  initial begin
    #(5.0 * 150000);
    chk(0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [1:0] c0;
    bit sawErr;
    repeat (3) @(negedge clk);
    chk(csN && scN && oeN && !outValid && !errTimeout && chanSel == 0,
        "R1 reset state", {csN, scN, oeN, outValid, errTimeout, chanSel}, 6'b111000);
    rstN = 1'b1;

    for (int cfg = 0; cfg < 8; cfg++) begin
      wideRead  = cfg[0];
      bipolar   = cfg[1];
      rightJust = cfg[2];
      for (int k = 0; k < 6; k++) begin
        checkSample(k == 2);
        if (k == 5 && cfg < 7) begin
          wideRead  = 1'((cfg + 1) >> 0);
          bipolar   = 1'((cfg + 1) >> 1);
          rightJust = 1'((cfg + 1) >> 2);
        end
        acceptOut();
      end
    end

    // status line never falls: error, channel unchanged, retry same channel
    wideRead = 1'b1; bipolar = 1'b1; rightJust = 1'b0;
    checkSample(0);
    noFall = 1;
    c0 = chanSel;
    acceptOut();
    sawErr = 0;
    for (int i = 0; i < 500 && !sawErr; i++) begin
      @(negedge clk);
      if (errTimeout) sawErr = 1;
    end
    chk(sawErr, "R11 timeout when status never falls", int'(sawErr), 1);
    chk(chanSel == c0 && !outValid, "R11 channel kept after no-fall", chanSel, c0);
    noFall = 0;
    checkSample(0);
    chk(outChan == c0, "R11 retry on same channel", outChan, c0);

    // status line falls but never rises: channel advanced, sample dropped
    noRise = 1;
    c0 = chanSel;
    acceptOut();
    sawErr = 0;
    for (int i = 0; i < 500 && !sawErr; i++) begin
      @(negedge clk);
      if (errTimeout) sawErr = 1;
    end
    chk(sawErr, "R11 timeout when status never rises", int'(sawErr), 1);
    chk(chanSel == 2'(c0 + 1) && !outValid, "R11 channel advanced after no-rise",
        chanSel, 2'(c0 + 1));
    @(negedge clk);
    chk(!errTimeout, "R11 error is a single pulse", errTimeout, 0);
    noRise = 0;
    checkSample(0);
    chk(outChan == 2'(c0 + 1), "R11 next channel after drop", outChan, 2'(c0 + 1));
    acceptOut();

    chk(earlyReads == 0, "R4 no read before conversion done", earlyReads, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule